// File: doc/BRIEF.md
# Frame Dimension Monitor

The monitor sits beside a packetised video stream and measures every frame that passes. The stream carries one or more pixels per beat. Each line packet is counted in beats, because the stream does not say how many pixels of the final beat are used. From the beat count the monitor derives a lowest and a highest possible pixel count for the line. It tracks the smallest lower bound and the largest upper bound across the frame, and it counts completed lines. When a frame closes, the monitor publishes these figures and compares them with the expected width and height. The result goes into one of two saturating counters, matching frames or mismatching frames. A third counter records frames whose closing marker reports a broken frame.

The block has two build variants, chosen by a parameter. In the full variant, a one-beat image-information packet supplies the expected size, and a one-beat end-of-field packet closes the frame. In the lite variant, software writes the expected size, a start-of-frame flag on the first beat of a new line packet closes the previous frame, and broken frames are never counted. Software reads the results through a small word-addressed register port. Writing to one address clears all three counters.

Top module: `frame_dim_monitor`

## Requirements
- R1: A beat is accepted when `vid_valid` and `vid_ready` are both high. A line packet (`vid_type` 0) spans B accepted beats, from `vid_sop` through `vid_eop`. With N = PIX_PER_BEAT, its pixel count is bounded below by N*(B-1)+1 and above by N*B.
- R2: When a frame closes, the published minimum width (address 2) becomes the smallest lower bound of that frame's lines. The published maximum width (address 3) becomes the largest upper bound. The published line count (address 4) becomes the number of completed lines. With N = 1 the minimum and the maximum are both the exact pixel count.
- R3: A closing frame matches when four conditions hold: expected_width - N < min_width, min_width <= expected_width, expected_width <= max_width, and max_width < expected_width + N. Its line count must also equal the expected height.
- R4: Each frame close adds one to the match counter (address 5) if the frame matches, and otherwise adds one to the mismatch counter (address 6).
- R5: In the full variant, an end-of-field packet (`vid_type` 2) whose `vid_data[0]` is 1 adds one to the broken-frame counter (address 7). In the lite variant, that counter stays 0 and end-of-field packets have no effect.
- R6: In the full variant, a frame closes on the sop beat of an end-of-field packet. In the lite variant, a frame closes on a line sop beat with `vid_sof` high, provided at least one line has completed. That beat's own line then counts toward the next frame.
- R7: In the full variant, the sop beat of an image-information packet (`vid_type` 1) loads the expected width from `vid_data[DIM_W-1:0]` and the expected height from `vid_data[2*DIM_W-1:DIM_W]`. These values read back at addresses 0 and 1, and register writes to those addresses are ignored. In the lite variant, writes to addresses 0 and 1 set the expected width and height.
- R8: A register write to address 8 sets all three counters to 0. This takes effect on the next read, and it takes priority over a frame that closes in the same cycle.
- R9: Each counter holds at its all-ones value instead of wrapping.
- R10: After reset, every readable register is 0. A read of address 8 or of any unmapped address returns 0. Reads are combinational: `reg_rdata` follows `reg_addr` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vid_valid | input | 1 | Stream beat valid |
| vid_ready | input | 1 | Stream beat ready (observed, not driven) |
| vid_sop | input | 1 | First beat of a packet |
| vid_eop | input | 1 | Last beat of a packet |
| vid_sof | input | 1 | Marks the first line of a frame (lite variant only) |
| vid_type | input | 2 | Packet type: 0 line, 1 image information, 2 end of field |
| vid_data | input | 2*DIM_W | Beat payload; carries the size fields and the broken flag |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | DIM_W | Register write data |
| reg_rdata | output | RD_W | Register read data, the wider of DIM_W and CNT_W |

## Verification
The bench changes stream inputs on falling edges, so each beat is captured at the next rising edge. A frame-close beat updates the published widths, the line count and the counters at that same rising edge. Register reads are combinational, so each result can be read back on the falling edge that removes the stimulus, one cycle after the closing beat was driven. The checks set the address there and sample a time step later, away from any clock edge. A counter clear that is written in the same cycle as a closing beat is read back only after that edge.

// File: rtl/frame_dim_monitor.sv
module frame_dim_monitor #(
  parameter int PIX_PER_BEAT = 2,
  parameter int DIM_W        = 16,
  parameter int CNT_W        = 16,
  parameter bit LITE         = 1'b0,
  localparam int DATA_W      = 2 * DIM_W,
  localparam int RD_W        = (DIM_W > CNT_W) ? DIM_W : CNT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vid_valid,
  input  logic              vid_ready,
  input  logic              vid_sop,
  input  logic              vid_eop,
  input  logic              vid_sof,
  input  logic [1:0]        vid_type,
  input  logic [DATA_W-1:0] vid_data,
  input  logic              reg_wr,
  input  logic [3:0]        reg_addr,
  input  logic [DIM_W-1:0]  reg_wdata,
  output logic [RD_W-1:0]   reg_rdata
);
  localparam logic [DIM_W-1:0] PIX_C = DIM_W'(PIX_PER_BEAT);
  localparam logic [DIM_W:0]   PIX_X = (DIM_W+1)'(PIX_PER_BEAT);

  logic [DIM_W-1:0] beat_cnt, run_min, run_max, run_lines;
  logic [DIM_W-1:0] pub_min, pub_max, pub_lines, exp_w, exp_h;
  logic [CNT_W-1:0] match_cnt, mismatch_cnt, broken_cnt;
  logic             frame_end, brk_evt;

  wire beat      = vid_valid & vid_ready;
  wire line_beat = beat & (vid_type == 2'd0);
  wire line_end  = line_beat & vid_eop;
  wire clear     = reg_wr & (reg_addr == 4'd8);

  wire [DIM_W-1:0] cur_beats = (vid_sop ? '0 : beat_cnt) + DIM_W'(1);
  wire [DIM_W-1:0] lo_b      = PIX_C * (cur_beats - DIM_W'(1)) + DIM_W'(1);
  wire [DIM_W-1:0] hi_b      = PIX_C * cur_beats;

  wire [DIM_W:0] min_x = {1'b0, run_min};
  wire [DIM_W:0] max_x = {1'b0, run_max};
  wire [DIM_W:0] exp_x = {1'b0, exp_w};
  wire match_ok = (min_x + PIX_X > exp_x) && (min_x <= exp_x) &&
                  (max_x >= exp_x) && (max_x < exp_x + PIX_X) &&
                  (run_lines == exp_h);

  generate
    if (LITE) begin : g_lite
      wire unused_lite = ^vid_data;
      assign frame_end = line_beat & vid_sop & vid_sof & (run_lines != '0);
      assign brk_evt   = 1'b0;
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          exp_w <= '0;
          exp_h <= '0;
        end else if (reg_wr) begin
          if (reg_addr == 4'd0) exp_w <= reg_wdata;
          if (reg_addr == 4'd1) exp_h <= reg_wdata;
        end
      end
    end else begin : g_full
      wire unused_full = ^{reg_wdata, vid_sof};
      assign frame_end = beat & vid_sop & (vid_type == 2'd2);
      assign brk_evt   = frame_end & vid_data[0];
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          exp_w <= '0;
          exp_h <= '0;
        end else if (beat & vid_sop & (vid_type == 2'd1)) begin
          exp_w <= vid_data[DIM_W-1:0];
          exp_h <= vid_data[DATA_W-1:DIM_W];
        end
      end
    end
  endgenerate

  function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] c);
    return c + CNT_W'(c != '1);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) beat_cnt <= '0;
    else if (line_beat) beat_cnt <= vid_eop ? '0 : cur_beats;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_min   <= '1;
      run_max   <= '0;
      run_lines <= '0;
      pub_min   <= '0;
      pub_max   <= '0;
      pub_lines <= '0;
    end else if (frame_end) begin
      pub_min   <= run_min;
      pub_max   <= run_max;
      pub_lines <= run_lines;
      run_min   <= line_end ? lo_b : '1;
      run_max   <= line_end ? hi_b : '0;
      run_lines <= line_end ? DIM_W'(1) : '0;
    end else if (line_end) begin
      if (lo_b < run_min) run_min <= lo_b;
      if (hi_b > run_max) run_max <= hi_b;
      run_lines <= run_lines + DIM_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      match_cnt    <= '0;
      mismatch_cnt <= '0;
      broken_cnt   <= '0;
    end else begin
      if (frame_end &&  match_ok) match_cnt    <= sat_inc(match_cnt);
      if (frame_end && !match_ok) mismatch_cnt <= sat_inc(mismatch_cnt);
      if (brk_evt)                broken_cnt   <= sat_inc(broken_cnt);
    end
  end

  always_comb begin
    case (reg_addr)
      4'd0:    reg_rdata = RD_W'(exp_w);
      4'd1:    reg_rdata = RD_W'(exp_h);
      4'd2:    reg_rdata = RD_W'(pub_min);
      4'd3:    reg_rdata = RD_W'(pub_max);
      4'd4:    reg_rdata = RD_W'(pub_lines);
      4'd5:    reg_rdata = RD_W'(match_cnt);
      4'd6:    reg_rdata = RD_W'(mismatch_cnt);
      4'd7:    reg_rdata = RD_W'(broken_cnt);
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/frame_dim_monitor_chk.sv
module frame_dim_monitor_chk #(
  parameter int DIM_W = 16,
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             clear,
  input logic [CNT_W-1:0] match_cnt,
  input logic [CNT_W-1:0] mismatch_cnt,
  input logic [CNT_W-1:0] broken_cnt,
  input logic [DIM_W-1:0] pub_min,
  input logic [DIM_W-1:0] pub_max,
  input logic [DIM_W-1:0] pub_lines
);
  p_clear_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (match_cnt == '0 && mismatch_cnt == '0 && broken_cnt == '0));

  p_no_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && mismatch_cnt == '1) |=> mismatch_cnt == '1);

  p_no_wrap_brk_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && broken_cnt == '1) |=> broken_cnt == '1);

  p_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !clear |=> (match_cnt == $past(match_cnt) ||
                match_cnt == $past(match_cnt) + CNT_W'(1)));

  p_one_verdict_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !clear |=> !(match_cnt != $past(match_cnt) && mismatch_cnt != $past(mismatch_cnt)));

  p_min_le_max_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (pub_lines != '0) |-> (pub_min <= pub_max));
endmodule

bind frame_dim_monitor frame_dim_monitor_chk #(.DIM_W(DIM_W), .CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .clear(clear),
  .match_cnt(match_cnt), .mismatch_cnt(mismatch_cnt), .broken_cnt(broken_cnt),
  .pub_min(pub_min), .pub_max(pub_max), .pub_lines(pub_lines)
);

// File: tb/frame_dim_monitor_tb_top.sv
module frame_dim_monitor_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DIM_W = 16;
  localparam int CNT_W = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic vid_valid = 1'b0, vid_ready = 1'b1, vid_sop = 1'b0, vid_eop = 1'b0, vid_sof = 1'b0;
  logic [1:0] vid_type = 2'd0;
  logic [2*DIM_W-1:0] vid_data = '0;
  logic reg_wr = 1'b0;
  logic [3:0] reg_addr = 4'd0;
  logic [DIM_W-1:0] reg_wdata = '0;
  logic [15:0] rd_full, rd_lite, rd_one;
  int errors = 0, checks = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  frame_dim_monitor #(.PIX_PER_BEAT(2), .DIM_W(DIM_W), .CNT_W(CNT_W), .LITE(1'b0)) dut_i (
    .clk(clk), .rst_n(rst_n), .vid_valid(vid_valid), .vid_ready(vid_ready),
    .vid_sop(vid_sop), .vid_eop(vid_eop), .vid_sof(vid_sof), .vid_type(vid_type),
    .vid_data(vid_data), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(rd_full));

  frame_dim_monitor #(.PIX_PER_BEAT(2), .DIM_W(DIM_W), .CNT_W(CNT_W), .LITE(1'b1)) dut_lite_i (
    .clk(clk), .rst_n(rst_n), .vid_valid(vid_valid), .vid_ready(vid_ready),
    .vid_sop(vid_sop), .vid_eop(vid_eop), .vid_sof(vid_sof), .vid_type(vid_type),
    .vid_data(vid_data), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(rd_lite));

  frame_dim_monitor #(.PIX_PER_BEAT(1), .DIM_W(DIM_W), .CNT_W(CNT_W), .LITE(1'b0)) dut_one_i (
    .clk(clk), .rst_n(rst_n), .vid_valid(vid_valid), .vid_ready(vid_ready),
    .vid_sop(vid_sop), .vid_eop(vid_eop), .vid_sof(vid_sof), .vid_type(vid_type),
    .vid_data(vid_data), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(rd_one));

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // which: 0 full N=2, 1 lite N=2, 2 full N=1
  task automatic chk(input int which, input logic [3:0] a, input logic [15:0] exp, input string tag);
    logic [15:0] act;
    reg_addr = a;
    #1;
    act = (which == 0) ? rd_full : (which == 1) ? rd_lite : rd_one;
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: dut%0d addr %0d actual %0d expected %0d", tag, which, a, act, exp);
    end
  endtask

  task automatic send(input logic [1:0] t, input logic s, input logic e, input logic f,
                      input logic [2*DIM_W-1:0] d);
    @(negedge clk);
    vid_valid = 1'b1; vid_type = t; vid_sop = s; vid_eop = e; vid_sof = f; vid_data = d;
  endtask

  task automatic idle();
    @(negedge clk);
    vid_valid = 1'b0; vid_sop = 1'b0; vid_eop = 1'b0; vid_sof = 1'b0;
  endtask

  task automatic line(input int n, input logic f);
    for (int i = 0; i < n; i++) send(2'd0, i == 0, i == n - 1, f && i == 0, '0);
  endtask

  task automatic info(input int w, input int h);
    send(2'd1, 1'b1, 1'b1, 1'b0, {DIM_W'(h), DIM_W'(w)});
  endtask

  task automatic eof(input logic b);
    send(2'd2, 1'b1, 1'b1, 1'b0, {{(2*DIM_W-1){1'b0}}, b});
  endtask

  task automatic wr(input logic [3:0] a, input int d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = DIM_W'(d);
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic t_reset();
    for (int a = 0; a < 8; a++) chk(0, 4'(a), 16'd0, "R10 reset value");
    chk(1, 4'd5, 16'd0, "R10 reset lite match");
    chk(0, 4'd9, 16'd0, "R10 unmapped read");
  endtask

  task automatic t_setup();
    wr(4'd0, 8);
    wr(4'd1, 2);
    chk(0, 4'd0, 16'd0, "R7 full ignores width write");
    chk(1, 4'd0, 16'd8, "R7 lite width write");
    chk(1, 4'd1, 16'd2, "R7 lite height write");
  endtask

  task automatic t_frame1();
    info(8, 2); line(4, 1'b1); line(4, 1'b0); eof(1'b0); idle();
    chk(0, 4'd0, 16'd8, "R7 info width");
    chk(0, 4'd1, 16'd2, "R7 info height");
    chk(0, 4'd2, 16'd7, "R1 lower bound 2*(4-1)+1");
    chk(0, 4'd3, 16'd8, "R1 upper bound 2*4");
    chk(0, 4'd4, 16'd2, "R2 line count");
    chk(0, 4'd5, 16'd1, "R3 window match");
    chk(0, 4'd6, 16'd0, "R4 no mismatch");
    chk(0, 4'd7, 16'd0, "R5 clean eof");
    chk(2, 4'd2, 16'd4, "R2 exact min N=1");
    chk(2, 4'd3, 16'd4, "R2 exact max N=1");
    chk(2, 4'd6, 16'd1, "R3 N=1 width 4 vs 8");
    chk(1, 4'd5, 16'd0, "R6 lite frame still open");
  endtask

  task automatic t_frame2();
    info(3, 3); line(3, 1'b1); line(3, 1'b0); line(3, 1'b0); eof(1'b1); idle();
    chk(0, 4'd6, 16'd1, "R3 min 5 above width 3");
    chk(0, 4'd5, 16'd1, "R4 match held");
    chk(0, 4'd7, 16'd1, "R5 broken eof");
    chk(2, 4'd5, 16'd1, "R3 N=1 exact match");
    chk(2, 4'd2, 16'd3, "R2 N=1 width");
    chk(1, 4'd5, 16'd1, "R6 lite closed on sof");
    chk(1, 4'd2, 16'd7, "R6 lite min");
    chk(1, 4'd3, 16'd8, "R6 lite max");
    chk(1, 4'd4, 16'd2, "R6 lite lines");
  endtask

  task automatic t_frame3();
    line(1, 1'b1); line(3, 1'b0); eof(1'b0); idle();
    chk(0, 4'd2, 16'd1, "R2 min of lower bounds");
    chk(0, 4'd3, 16'd6, "R2 max of upper bounds");
    chk(0, 4'd6, 16'd2, "R4 mismatch count");
    chk(2, 4'd3, 16'd3, "R2 N=1 max");
    chk(1, 4'd6, 16'd1, "R3 lite 3 lines vs 2");
    chk(1, 4'd2, 16'd5, "R2 lite min");
    line(1, 1'b1); idle();
    chk(1, 4'd2, 16'd1, "R6 lite single beat closes");
    chk(1, 4'd3, 16'd6, "R6 lite max");
    chk(1, 4'd6, 16'd2, "R4 lite mismatch");
    chk(1, 4'd7, 16'd0, "R5 lite broken stays 0");
  endtask

  task automatic t_clear_sat();
    wr(4'd8, 0);
    chk(0, 4'd5, 16'd0, "R8 match cleared");
    chk(0, 4'd6, 16'd0, "R8 mismatch cleared");
    chk(0, 4'd7, 16'd0, "R8 broken cleared");
    chk(1, 4'd6, 16'd0, "R8 lite cleared");
    chk(0, 4'd8, 16'd0, "R10 clear address reads 0");
    for (int i = 0; i < 9; i++) eof(1'b1);
    idle();
    chk(0, 4'd6, 16'd7, "R9 mismatch saturates");
    chk(0, 4'd7, 16'd7, "R9 broken saturates");
    chk(2, 4'd7, 16'd7, "R9 N=1 broken saturates");
    chk(1, 4'd7, 16'd0, "R5 lite ignores eof");
    chk(1, 4'd6, 16'd0, "R5 lite eof no close");
    @(negedge clk);
    vid_valid = 1'b1; vid_type = 2'd2; vid_sop = 1'b1; vid_eop = 1'b1; vid_data = 1;
    reg_wr = 1'b1; reg_addr = 4'd8;
    @(negedge clk);
    reg_wr = 1'b0; vid_valid = 1'b0; vid_sop = 1'b0; vid_eop = 1'b0;
    chk(0, 4'd6, 16'd0, "R8 clear beats close");
    chk(0, 4'd7, 16'd0, "R8 clear beats broken");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_setup();
    t_frame1();
    t_frame2();
    t_frame3();
    t_clear_sat();
    done = 1'b1;
    report();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
    end
  end
endmodule